// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This block works out which parallel NOR flash part sits on a bus. A one-cycle `start` request while idle runs a fixed probe. The probe first writes the three-step auto-select command. It then reads the manufacturer word and the device word, and matches them against a parameter table of known parts. Each table entry holds a manufacturer byte, a 16-bit device code, the log2 of the part size on a 16-bit bus, and a sector count.

The result is reported as a command family, a table index, a total size in bytes and a sector count. The two families are unlock-style and status-register-style. One probe serves both families, because the status-register family ignores the two unlock writes. After a part is recognised, the block writes the return-to-read command that suits the detected family. On a 32-bit bus every command byte is repeated in each 16-bit lane, and all reported sizes double.

The control is one state machine with nine states:

- `S_IDLE`: waits for `start`.
- `S_UNLOCK_A`, `S_UNLOCK_B`, `S_AUTOSEL`: issue the three auto-select writes.
- `S_READ_MFR`: reads the manufacturer word.
- `S_READ_DEV`: reads the device word. When the manufacturer is not recognised it leaves at once for `S_FINISH`.
- `S_DECIDE`: commits the result. It goes to `S_EXIT_CMD` on a table hit and to `S_FINISH` otherwise.
- `S_EXIT_CMD`: writes the return-to-read command and then goes to `S_FINISH`.
- `S_FINISH`: pulses `done` and returns to `S_IDLE`.

The three write states advance in sequence, each when its bus transfer completes.

Top module: `nor_id_probe`

## Requirements
- R1: A start request while idle issues three writes in this order: (word 0x555, 0xAA), then (word 0x2AA, 0x55), then (word 0x555, 0x90). Each data byte sits in the low byte of every 16-bit lane with a zero high byte, for example 0x00AA00AA on a 32-bit bus.
- R2: After the writes, the block reads word 0 and then word 1. Only bits [7:0] of word 0 decide the manufacturer: 0x01 means unlock-style (family 1) and 0x89 means status-register-style (family 2).
- R3: Word 1 must equal the entry's 16-bit device code repeated in every lane, compared over the full bus width. Word 1 is not read at all when the manufacturer byte is unrecognised.
- R4: On a match, the block reports:
  - `family`;
  - `dev_type`, the table index;
  - `sect_count`;
  - `size_bytes`, equal to 2^log2 on a 16-bit bus and twice that on a 32-bit bus.

  In the default table, index 0 is code 0x22DA (19 sectors, 1 MiB/16 bit), index 1 is 0x22D7 (128, 8 MiB), and index 6 is 0x88C5 (71, 4 MiB).
- R5: An unrecognised manufacturer or device code gives the following, and no return-to-read write is issued:
  - `unknown`=1;
  - `size_bytes`=0, `sect_count`=0, `family`=0.
- R6: After a match, one write to word 0 follows, carrying 0xF0 for family 1 or 0xFF for family 2, lane-replicated as in R1.
- R7: Each transfer holds `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` until a cycle with `bus_ready` high, and read data is taken in that cycle. Any number of wait cycles is accepted.
- R8: `done` is high for exactly one cycle at the end of a probe. `busy` is high from the cycle after the accepted start up to and including the `done` cycle.
- R9: A start request while `busy` is high, including the `done` cycle, is ignored and causes no further bus transfers.
- R10: After reset, `busy`, `done`, `bus_valid` and `unknown` are 0, and `size_bytes` and `sect_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Probe request, accepted only when idle |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| unknown | output | 1 | Last probe found no match |
| family | output | 2 | 0 none, 1 unlock-style, 2 status-register-style |
| dev_type | output | IDX_W | Matching table index |
| size_bytes | output | 32 | Total size in bytes |
| sect_count | output | 8 | Number of sectors |
| bus_valid | output | 1 | Transfer request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Word address |
| bus_wdata | output | BUS_W | Write data |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_rdata | input | BUS_W | Read data, valid with `bus_ready` |

## Verification
A new start request can arrive in the very cycle that `done` pulses, when the block is about to return to idle. The bench provokes this by raising `start` in the cycle where it sees `done` high, and also once in the middle of a probe. It judges the result in two ways: `busy` must fall in the next cycle, and the bus model must log no transfer beyond the six of the first probe. The bus model also adds wait cycles, so that the handshake hold and the capture on `bus_ready` can be judged.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

    typedef enum logic [1:0] {
        FAM_NONE   = 2'd0,
        FAM_UNLOCK = 2'd1,
        FAM_STATUS = 2'd2
    } fam_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLOCK_A,
        S_UNLOCK_B,
        S_AUTOSEL,
        S_READ_MFR,
        S_READ_DEV,
        S_DECIDE,
        S_EXIT_CMD,
        S_FINISH
    } state_e;

    localparam logic [11:0] OFS_A = 12'h555;
    localparam logic [11:0] OFS_B = 12'h2AA;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
    localparam logic [7:0] CMD_READ_UL  = 8'hF0;
    localparam logic [7:0] CMD_READ_SR  = 8'hFF;

    // Default part table, entry i in slice i (entry 0 rightmost).
    localparam int TBL_N = 10;
    localparam logic [TBL_N*8-1:0]  TBL_MFR  = {8'h89, 8'h89, 8'h89, 8'h89, 8'h89,
                                                8'h89, 8'h89, 8'h89, 8'h01, 8'h01};
    localparam logic [TBL_N*16-1:0] TBL_CODE = {16'h8899, 16'h88CD, 16'h8897, 16'h88C5, 16'h8891,
                                                16'h88C3, 16'h8893, 16'h88C1, 16'h22D7, 16'h22DA};
    localparam logic [TBL_N*5-1:0]  TBL_LOG2 = {5'd23, 5'd23, 5'd22, 5'd22, 5'd21,
                                                5'd21, 5'd20, 5'd20, 5'd23, 5'd20};
    localparam logic [TBL_N*8-1:0]  TBL_SECT = {8'd135, 8'd135, 8'd71, 8'd71, 8'd39,
                                                8'd39,  8'd23,  8'd23, 8'd128, 8'd19};

endpackage

// File: rtl/nor_id_classify.sv
module nor_id_classify
    import nor_probe_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int N_DEV = TBL_N,
    parameter int IDX_W = 4,
    parameter logic [7:0] MFR_UNLOCK = 8'h01,
    parameter logic [7:0] MFR_STATUS = 8'h89,
    parameter logic [N_DEV*8-1:0]  DEV_MFR  = TBL_MFR,
    parameter logic [N_DEV*16-1:0] DEV_CODE = TBL_CODE,
    parameter logic [N_DEV*5-1:0]  DEV_LOG2 = TBL_LOG2,
    parameter logic [N_DEV*8-1:0]  DEV_SECT = TBL_SECT
) (
    input  logic [7:0]       mfr_byte,
    input  logic [BUS_W-1:0] dev_word,
    output logic             mfr_known,
    output fam_e             family,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [31:0]      size_bytes,
    output logic [7:0]       sectors
);

    localparam int LANES   = BUS_W / 16;
    localparam int LANE_SH = (LANES > 1) ? $clog2(LANES) : 0;

    logic [N_DEV-1:0] match;
    logic [4:0]       log2_sel;

    always_comb begin
        if (mfr_byte == MFR_UNLOCK)      family = FAM_UNLOCK;
        else if (mfr_byte == MFR_STATUS) family = FAM_STATUS;
        else                             family = FAM_NONE;
    end

    assign mfr_known = (family != FAM_NONE);

    // One comparator per table entry; the device word must carry the code in every lane.
    for (genvar i = 0; i < N_DEV; i++) begin : g_entry
        assign match[i] = mfr_known
                       && (DEV_MFR[i*8 +: 8] == mfr_byte)
                       && (dev_word == {LANES{DEV_CODE[i*16 +: 16]}});
    end

    always_comb begin
        hit      = 1'b0;
        idx      = '0;
        log2_sel = '0;
        sectors  = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                idx      = IDX_W'(i);
                log2_sel = DEV_LOG2[i*5 +: 5];
                sectors  = DEV_SECT[i*8 +: 8];
            end
        end
    end

    assign size_bytes = hit ? (32'd1 << (6'(log2_sel) + 6'(LANE_SH))) : 32'd0;

endmodule

// File: rtl/nor_probe_seq.sv
module nor_probe_seq
    import nor_probe_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mfr_known,
    input  logic              dev_hit,
    input  fam_e              family,
    input  logic              bus_ready,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [7:0]        mfr_q,
    output logic [BUS_W-1:0]  dev_q,
    output logic              commit,
    output logic              busy,
    output logic              done
);

    localparam int LANES = BUS_W / 16;

    state_e state, state_nx;

    function automatic logic [BUS_W-1:0] lanes(input logic [7:0] b);
        return {LANES{8'h00, b}};
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start)     state_nx = S_UNLOCK_A;
            S_UNLOCK_A: if (bus_ready) state_nx = S_UNLOCK_B;
            S_UNLOCK_B: if (bus_ready) state_nx = S_AUTOSEL;
            S_AUTOSEL:  if (bus_ready) state_nx = S_READ_MFR;
            S_READ_MFR: if (bus_ready) state_nx = S_READ_DEV;
            S_READ_DEV: begin
                if (!mfr_known)     state_nx = S_FINISH;
                else if (bus_ready) state_nx = S_DECIDE;
            end
            S_DECIDE:   state_nx = dev_hit ? S_EXIT_CMD : S_FINISH;
            S_EXIT_CMD: if (bus_ready) state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        commit    = 1'b0;
        done      = 1'b0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_IDLE: ;
            S_UNLOCK_A: begin
                bus_valid = 1'b1; bus_we = 1'b1;
                bus_addr  = ADDR_W'(OFS_A); bus_wdata = lanes(CMD_UNLOCK_A);
            end
            S_UNLOCK_B: begin
                bus_valid = 1'b1; bus_we = 1'b1;
                bus_addr  = ADDR_W'(OFS_B); bus_wdata = lanes(CMD_UNLOCK_B);
            end
            S_AUTOSEL: begin
                bus_valid = 1'b1; bus_we = 1'b1;
                bus_addr  = ADDR_W'(OFS_A); bus_wdata = lanes(CMD_AUTOSEL);
            end
            S_READ_MFR: begin
                bus_valid = 1'b1;
                bus_addr  = ADDR_W'(0);
            end
            S_READ_DEV: begin
                bus_valid = mfr_known;
                bus_addr  = ADDR_W'(1);
                commit    = !mfr_known;
            end
            S_DECIDE: commit = 1'b1;
            S_EXIT_CMD: begin
                bus_valid = 1'b1; bus_we = 1'b1;
                bus_addr  = ADDR_W'(0);
                bus_wdata = lanes((family == FAM_UNLOCK) ? CMD_READ_UL : CMD_READ_SR);
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // Captured identification words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mfr_q <= '0;
            dev_q <= '0;
        end else begin
            if (state == S_READ_MFR && bus_ready) mfr_q <= bus_rdata[7:0];
            if (state == S_READ_DEV && bus_valid && bus_ready) dev_q <= bus_rdata;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
                                       && $stable(bus_wdata) && $stable(bus_we)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_exit_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && busy && $past(state) == S_DECIDE) |-> dev_hit);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);

    if (BUS_W > 16) begin : g_lane_chk
        p_lane_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_we) |-> (bus_wdata[15:0] == bus_wdata[BUS_W-1 -: 16]));
    end

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
    import nor_probe_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 20,
    parameter int N_DEV  = TBL_N,
    parameter logic [7:0] MFR_UNLOCK = 8'h01,
    parameter logic [7:0] MFR_STATUS = 8'h89,
    parameter logic [N_DEV*8-1:0]  DEV_MFR  = TBL_MFR,
    parameter logic [N_DEV*16-1:0] DEV_CODE = TBL_CODE,
    parameter logic [N_DEV*5-1:0]  DEV_LOG2 = TBL_LOG2,
    parameter logic [N_DEV*8-1:0]  DEV_SECT = TBL_SECT,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              unknown,
    output logic [1:0]        family,
    output logic [IDX_W-1:0]  dev_type,
    output logic [31:0]       size_bytes,
    output logic [7:0]        sect_count,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_ready,
    input  logic [BUS_W-1:0]  bus_rdata
);

    logic [7:0]       mfr_q;
    logic [BUS_W-1:0] dev_q;
    logic             commit;
    logic             mfr_known;
    logic             dev_hit;
    fam_e             fam_c;
    logic [IDX_W-1:0] idx_c;
    logic [31:0]      size_c;
    logic [7:0]       sect_c;

    nor_probe_seq #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mfr_known (mfr_known),
        .dev_hit   (dev_hit),
        .family    (fam_c),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mfr_q     (mfr_q),
        .dev_q     (dev_q),
        .commit    (commit),
        .busy      (busy),
        .done      (done)
    );

    nor_id_classify #(
        .BUS_W(BUS_W), .N_DEV(N_DEV), .IDX_W(IDX_W),
        .MFR_UNLOCK(MFR_UNLOCK), .MFR_STATUS(MFR_STATUS),
        .DEV_MFR(DEV_MFR), .DEV_CODE(DEV_CODE),
        .DEV_LOG2(DEV_LOG2), .DEV_SECT(DEV_SECT)
    ) u_cls (
        .mfr_byte   (mfr_q),
        .dev_word   (dev_q),
        .mfr_known  (mfr_known),
        .family     (fam_c),
        .hit        (dev_hit),
        .idx        (idx_c),
        .size_bytes (size_c),
        .sectors    (sect_c)
    );

    // Result registers, loaded once per probe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unknown    <= 1'b0;
            family     <= FAM_NONE;
            dev_type   <= '0;
            size_bytes <= '0;
            sect_count <= '0;
        end else if (commit) begin
            unknown    <= !dev_hit;
            family     <= dev_hit ? fam_c : FAM_NONE;
            dev_type   <= dev_hit ? idx_c : '0;
            size_bytes <= size_c;
            sect_count <= sect_c;
        end
    end

    p_unknown_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unknown) |-> (size_bytes == 32'd0 && sect_count == 8'd0 && family == 2'd0));

    p_result_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(size_bytes) && $stable(sect_count) && $stable(unknown)));

endmodule

// File: tb/nor_id_probe_tb.sv
`timescale 1ns/1ps

module nor_flash_model #(
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          valid,
    input  logic          we,
    input  logic [19:0]   addr,
    input  logic [BW-1:0] wdata,
    output logic          ready,
    output logic [BW-1:0] rdata,
    input  logic [BW-1:0] mfr_word,
    input  logic [BW-1:0] dev_word,
    input  logic [7:0]    wait_n
);
    int            cnt;
    int            log_n;
    logic          log_we   [0:15];
    logic [19:0]   log_addr [0:15];
    logic [BW-1:0] log_data [0:15];

    initial begin
        ready = 1'b0;
        rdata = '0;
        cnt   = 0;
        log_n = 0;
        forever begin
            @(negedge clk);
            if (clr) begin
                log_n = 0; ready = 1'b0; cnt = 0;
            end else if (ready) begin
                ready = 1'b0; cnt = 0;
            end else if (valid) begin
                if (cnt >= int'(wait_n)) begin
                    ready = 1'b1;
                    rdata = (addr == 20'd0) ? mfr_word : (addr == 20'd1) ? dev_word : '0;
                    if (log_n < 16) begin
                        log_we[log_n]   = we;
                        log_addr[log_n] = addr;
                        log_data[log_n] = wdata;
                    end
                    log_n++;
                end else begin
                    cnt++;
                end
            end
        end
    end
endmodule

module nor_id_probe_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // 32-bit instance
    logic        start = 1'b0, clr = 1'b0;
    logic        busy, done, unknown, bus_valid, bus_we, bus_ready;
    logic [1:0]  family;
    logic [3:0]  dev_type;
    logic [31:0] size_bytes, bus_wdata, bus_rdata;
    logic [7:0]  sect_count;
    logic [19:0] bus_addr;
    logic [31:0] m_mfr = '0, m_dev = '0;
    logic [7:0]  m_wait = '0;

    nor_id_probe #(.BUS_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .unknown(unknown), .family(family), .dev_type(dev_type),
        .size_bytes(size_bytes), .sect_count(sect_count),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    nor_flash_model #(.BW(32)) u_mem (
        .clk(clk), .clr(clr), .valid(bus_valid), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .ready(bus_ready), .rdata(bus_rdata),
        .mfr_word(m_mfr), .dev_word(m_dev), .wait_n(m_wait)
    );

    // 16-bit instance
    logic        start16 = 1'b0;
    logic        busy16, done16, unknown16, valid16, we16, ready16;
    logic [1:0]  family16;
    logic [3:0]  type16;
    logic [31:0] size16;
    logic [15:0] wdata16, rdata16;
    logic [7:0]  sect16;
    logic [19:0] addr16;
    logic [15:0] m_mfr16 = '0, m_dev16 = '0;

    nor_id_probe #(.BUS_W(16)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .start(start16), .busy(busy16), .done(done16),
        .unknown(unknown16), .family(family16), .dev_type(type16),
        .size_bytes(size16), .sect_count(sect16),
        .bus_valid(valid16), .bus_we(we16), .bus_addr(addr16),
        .bus_wdata(wdata16), .bus_ready(ready16), .bus_rdata(rdata16)
    );

    nor_flash_model #(.BW(16)) u_mem16 (
        .clk(clk), .clr(clr), .valid(valid16), .we(we16), .addr(addr16),
        .wdata(wdata16), .ready(ready16), .rdata(rdata16),
        .mfr_word(m_mfr16), .dev_word(m_dev16), .wait_n(m_wait)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_done32();
        int k;
        k = 0;
        while (done !== 1'b1 && k < 400) begin @(negedge clk); k++; end
        chk("R8", "probe reached done", 32'(done), 32'd1);
    endtask

    task automatic launch32(input logic [31:0] mfr, input logic [31:0] dev, input logic [7:0] wt);
        @(negedge clk);
        m_mfr = mfr; m_dev = dev; m_wait = wt; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "busy after start", 32'(busy), 32'd1);
    endtask

    task automatic chk_wr32(input string req, input int k, input logic [19:0] a, input logic [7:0] b);
        chk(req, $sformatf("entry %0d is write", k), 32'(u_mem.log_we[k]), 32'd1);
        chk(req, $sformatf("entry %0d addr", k), 32'(u_mem.log_addr[k]), 32'(a));
        chk(req, $sformatf("entry %0d data", k), u_mem.log_data[k], {2{8'h00, b}});
    endtask

    task automatic chk_rd32(input string req, input int k, input logic [19:0] a);
        chk(req, $sformatf("entry %0d is read", k), 32'(u_mem.log_we[k]), 32'd0);
        chk(req, $sformatf("entry %0d addr", k), 32'(u_mem.log_addr[k]), 32'(a));
    endtask

    task automatic t_reset();
        chk("R10", "busy", 32'(busy), 32'd0);
        chk("R10", "done", 32'(done), 32'd0);
        chk("R10", "bus_valid", 32'(bus_valid), 32'd0);
        chk("R10", "unknown", 32'(unknown), 32'd0);
        chk("R10", "size", size_bytes, 32'd0);
        chk("R10", "sectors", 32'(sect_count), 32'd0);
    endtask

    // R1 R2 R4 R6: unlock family, junk above the low manufacturer byte
    task automatic t_unlock_part();
        launch32(32'h1234_5601, 32'h22D7_22D7, 8'd0);
        wait_done32();
        chk("R6", "transfer count", 32'(u_mem.log_n), 32'd6);
        chk_wr32("R1", 0, 20'h555, 8'hAA);
        chk_wr32("R1", 1, 20'h2AA, 8'h55);
        chk_wr32("R1", 2, 20'h555, 8'h90);
        chk_rd32("R2", 3, 20'd0);
        chk_rd32("R2", 4, 20'd1);
        chk_wr32("R6", 5, 20'd0, 8'hF0);
        chk("R4", "size 32-bit", size_bytes, 32'h0100_0000);
        chk("R4", "sectors", 32'(sect_count), 32'd128);
        chk("R4", "family", 32'(family), 32'd1);
        chk("R4", "type", 32'(dev_type), 32'd1);
        chk("R2", "unknown", 32'(unknown), 32'd0);
    endtask

    // R7 with wait states, status family
    task automatic t_status_part();
        launch32(32'h0000_0089, 32'h88C5_88C5, 8'd3);
        wait_done32();
        chk("R7", "transfer count", 32'(u_mem.log_n), 32'd6);
        chk("R7", "size", size_bytes, 32'h0080_0000);
        chk("R7", "sectors", 32'(sect_count), 32'd71);
        chk("R4", "family", 32'(family), 32'd2);
        chk("R4", "type", 32'(dev_type), 32'd6);
        chk_wr32("R6", 5, 20'd0, 8'hFF);
    endtask

    // R3: device code present in one lane only
    task automatic t_half_code();
        launch32(32'h0000_0089, 32'h88C5_0000, 8'd2);
        wait_done32();
        chk("R3", "unknown", 32'(unknown), 32'd1);
        chk("R5", "size", size_bytes, 32'd0);
        chk("R5", "sectors", 32'(sect_count), 32'd0);
        chk("R5", "family", 32'(family), 32'd0);
        chk("R5", "no exit write", 32'(u_mem.log_n), 32'd5);
    endtask

    // R3 R5: unknown manufacturer, valid device code
    task automatic t_bad_mfr();
        launch32(32'h0000_0020, 32'h22D7_22D7, 8'd1);
        wait_done32();
        chk("R3", "no device read", 32'(u_mem.log_n), 32'd4);
        chk_rd32("R3", 3, 20'd0);
        chk("R5", "unknown", 32'(unknown), 32'd1);
        chk("R5", "size", size_bytes, 32'd0);
    endtask

    // R4 on a 16-bit bus
    task automatic t_narrow();
        int k;
        @(negedge clk);
        m_mfr16 = 16'h0001; m_dev16 = 16'h22DA; m_wait = 8'd1; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start16 = 1'b1;
        @(negedge clk);
        start16 = 1'b0;
        k = 0;
        while (done16 !== 1'b1 && k < 400) begin @(negedge clk); k++; end
        chk("R8", "narrow done", 32'(done16), 32'd1);
        chk("R4", "narrow size", size16, 32'h0010_0000);
        chk("R4", "narrow sectors", 32'(sect16), 32'd19);
        chk("R4", "narrow type", 32'(type16), 32'd0);
        chk("R1", "narrow first data", 32'(u_mem16.log_data[0]), 32'h0000_00AA);
        chk("R6", "narrow exit data", 32'(u_mem16.log_data[5]), 32'h0000_00F0);
    endtask

    // R8 R9: start mid-probe and in the done cycle
    task automatic t_overlap();
        launch32(32'h0000_0001, 32'h22D7_22D7, 8'd0);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done32();
        chk("R8", "busy in done cycle", 32'(busy), 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "done is one cycle", 32'(done), 32'd0);
        chk("R9", "idle after done", 32'(busy), 32'd0);
        repeat (10) @(negedge clk);
        chk("R9", "still idle", 32'(busy), 32'd0);
        chk("R9", "no extra transfers", 32'(u_mem.log_n), 32'd6);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unlock_part();
        t_status_part();
        t_half_code();
        t_bad_mfr();
        t_narrow();
        t_overlap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule